// File: doc/BRIEF.md
# Banked Register Access Controller

This block sits behind a serial register-access port and in front of a byte-wide configuration memory. Each request carries an 8-bit register address, write data and a read or a write strobe. The block turns the address into a linear memory address, decides whether the current protection level permits the access, and either forwards it to the memory or refuses it. The lower quarter of the register space (0x00–0x3F) is a window onto one 64-byte bank picked by a bank-select register. The range 0x40–0xFF is a fixed region that is never affected by the bank choice.

Protection is kept by a small state machine with five states. LOAD is entered during reset. On the first clock after reset release it moves to the state that matches the preloaded 2-bit protection code. FREE (code 00), LIMITED (code 01) and SHIP1 (code 10) change on an accepted write to the protection register at 0x43. FREE and LIMITED go to whatever code is written. SHIP1 goes to SHIP2 when 11 is written, and to LIMITED for any other value. SHIP2 (code 11) has no exits. The codes map to three access levels: 00 is level 0, 01 is level 1, and 10 and 11 are both level 2.

Two registers are held inside the block rather than in memory. The bank-select register sits at 0x40 and the protection register at 0x43. The number of banks is 2 to the power of a preloaded 3-bit bank-count code, clamped to 2^BANK_W. Both preload inputs are sampled during the LOAD state.

Top module: `bank_access_ctrl`

## Requirements
- R1: While reset is low, `rd_data`, `refused` and `mem_we` are 0. In the first cycle after reset release (state LOAD) any request is refused and no memory write occurs. After that cycle, a read of 0x43 returns `{6'b0, cfg_prot}`.
- R2: For an address below 0x40, `mem_addr` is `{1'b1, bank, addr[5:0]}` (top bit at position BANK_W+6). A write to 0x40 stores `reg_wdata[BANK_W-1:0]`. A read of 0x40 returns the stored value, zero-extended. The new bank applies from the next request.
- R3: The bank count is 2^min(cfg_bank_code, BANK_W). The bank actually used is the stored bank-select value modulo that count.
- R4: For an address of 0x40 or above, `mem_addr` equals the address zero-extended, whatever the bank-select value.
- R5: At codes 00 and 01, an accepted write to 0x43 sets the code to `reg_wdata[1:0]`. The new code applies from the next request.
- R6: At code 10, a write to 0x43 moves the code to 11 if `reg_wdata[1:0]` is 11, and to 01 otherwise.
- R7: Code 11 is permanent until reset. A write to 0x43 at code 11 is refused, and 0x43 still reads back 11.
- R8: The configuration section is 0x44–0x5F. It is read/write at level 0, read-only at level 1, and fully refused at level 2.
- R9: The device section is 0x60–0x7F. It is read/write at levels 0 and 1 and read-only at level 2.
- R10: The bank window and the open addresses (0x41, 0x42, 0x80–0xFF) are read/write at every level.
- R11: For a refused request, `refused` is high for exactly the one cycle after the request and `rd_data` is 0x00 in that cycle. A refused write leaves `mem_we` low.
- R12: An accepted write raises `mem_we` in the request cycle, with `mem_wdata` equal to `reg_wdata`. An accepted read returns the addressed byte on `rd_data` in the next cycle, and `rd_data` is 0x00 otherwise. When both strobes are high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prot | input | 2 | Preloaded protection code, sampled in LOAD |
| cfg_bank_code | input | 3 | Preloaded bank-count code, sampled in LOAD |
| reg_addr | input | 8 | Register address of the request |
| reg_wdata | input | 8 | Write data of the request |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe (wins over a read) |
| rd_data | output | 8 | Read result, one cycle after the request |
| refused | output | 1 | One-cycle pulse after a refused request |
| mem_addr | output | BANK_W+7 | Linear memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, same cycle |

## Verification
The bench builds the block with BANK_W = 3, so the linear memory is only 1024 bytes and a bench model of it stays small. With this setting, bank-count codes 4 to 7 fall above the supported maximum, which exercises the clamp to eight banks. A bank-select value larger than the bank count exercises the modulo fold, and code 0 reduces the window to a single bank. Repeated resets with different preload codes start the state machine directly in SHIP1 and SHIP2 as well as in FREE.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_FREE,
        ST_LIMITED,
        ST_SHIP1,
        ST_SHIP2
    } prot_state_t;

    typedef enum logic [2:0] {
        SEC_USER,
        SEC_CONF,
        SEC_DEVICE,
        SEC_BANKSEL,
        SEC_PROT,
        SEC_OPEN
    } sect_t;

    localparam logic [7:0] WINDOW_END   = 8'h40;
    localparam logic [7:0] BANKSEL_ADDR = 8'h40;
    localparam logic [7:0] PROT_ADDR    = 8'h43;
    localparam logic [7:0] CONF_LO      = 8'h44;
    localparam logic [7:0] DEVICE_LO    = 8'h60;
    localparam logic [7:0] OPEN_LO      = 8'h80;

    function automatic prot_state_t code_to_state(input logic [1:0] code);
        prot_state_t s;
        unique case (code)
            2'b00:   s = ST_FREE;
            2'b01:   s = ST_LIMITED;
            2'b10:   s = ST_SHIP1;
            default: s = ST_SHIP2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bac_decode.sv
module bac_decode
    import bac_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int MEM_AW = BANK_W + 7
) (
    input  logic [7:0]        addr,
    input  logic [BANK_W-1:0] bank,
    output sect_t             sect,
    output logic [MEM_AW-1:0] mem_addr
);

    always_comb begin
        if (addr < WINDOW_END) begin
            sect     = SEC_USER;
            mem_addr = {1'b1, bank, addr[5:0]};
        end else begin
            mem_addr = MEM_AW'(addr);
            if (addr == BANKSEL_ADDR)
                sect = SEC_BANKSEL;
            else if (addr == PROT_ADDR)
                sect = SEC_PROT;
            else if (addr >= CONF_LO && addr < DEVICE_LO)
                sect = SEC_CONF;
            else if (addr >= DEVICE_LO && addr < OPEN_LO)
                sect = SEC_DEVICE;
            else
                sect = SEC_OPEN;
        end
    end

endmodule

// File: rtl/bac_bank_sel.sv
module bac_bank_sel #(
    parameter int BANK_W = 5,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] sel,
    output logic [BANK_W-1:0] bank
);

    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(BANK_W);

    logic [CODE_W-1:0] code_q;
    logic [BANK_W-1:0] sel_q;
    logic [BANK_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            sel_q  <= '0;
        end else begin
            if (load)
                code_q <= (cfg_code > CODE_MAX) ? CODE_MAX : cfg_code;
            if (wr)
                sel_q <= wdata;
        end
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_mask
        assign mask[i] = (code_q > CODE_W'(i));
    end

    assign sel  = sel_q;
    assign bank = sel_q & mask;

endmodule

// File: rtl/bac_prot_fsm.sv
module bac_prot_fsm
    import bac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_code,
    input  logic        prot_wr,
    input  logic [1:0]  wr_code,
    output prot_state_t state,
    output logic [1:0]  code,
    output logic        loading
);

    prot_state_t state_q;
    prot_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOAD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    state_d = code_to_state(cfg_code);
            ST_FREE,
            ST_LIMITED: if (prot_wr) state_d = code_to_state(wr_code);
            ST_SHIP1:   if (prot_wr) state_d = (wr_code == 2'b11) ? ST_SHIP2 : ST_LIMITED;
            ST_SHIP2:   state_d = ST_SHIP2;
            default:    state_d = ST_LOAD;
        endcase
    end

    always_comb begin
        loading = 1'b0;
        unique case (state_q)
            ST_LOAD:    begin code = 2'b00; loading = 1'b1; end
            ST_FREE:    code = 2'b00;
            ST_LIMITED: code = 2'b01;
            ST_SHIP1:   code = 2'b10;
            ST_SHIP2:   code = 2'b11;
            default:    code = 2'b00;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bac_policy.sv
module bac_policy
    import bac_pkg::*;
(
    input  prot_state_t state,
    input  sect_t       sect,
    input  logic        rd,
    input  logic        wr,
    output logic        rd_ok,
    output logic        wr_ok,
    output logic        deny
);

    logic rd_perm;
    logic wr_perm;
    logic op_rd;
    logic shipped;

    assign op_rd   = rd & ~wr;
    assign shipped = (state == ST_SHIP1) || (state == ST_SHIP2);

    always_comb begin
        rd_perm = 1'b1;
        wr_perm = 1'b1;
        unique case (sect)
            SEC_CONF: begin
                rd_perm = !shipped;
                wr_perm = (state == ST_FREE);
            end
            SEC_DEVICE: begin
                wr_perm = !shipped;
            end
            SEC_PROT: begin
                wr_perm = (state != ST_SHIP2);
            end
            default: begin
                rd_perm = 1'b1;
                wr_perm = 1'b1;
            end
        endcase
        if (state == ST_LOAD) begin
            rd_perm = 1'b0;
            wr_perm = 1'b0;
        end
    end

    assign rd_ok = op_rd & rd_perm;
    assign wr_ok = wr & wr_perm;
    assign deny  = (op_rd & ~rd_perm) | (wr & ~wr_perm);

endmodule

// File: rtl/bank_access_ctrl.sv
module bank_access_ctrl
    import bac_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int CODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_prot,
    input  logic [CODE_W-1:0]   cfg_bank_code,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_rd,
    input  logic                reg_wr,
    output logic [7:0]          rd_data,
    output logic                refused,
    output logic [BANK_W+6:0]   mem_addr,
    output logic                mem_we,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);

    localparam int MEM_AW = BANK_W + 7;

    prot_state_t       state;
    logic [1:0]        prot_code;
    logic              loading;
    sect_t             sect;
    logic [BANK_W-1:0] bank_sel;
    logic [BANK_W-1:0] bank_eff;
    logic              rd_ok;
    logic              wr_ok;
    logic              deny;
    logic              backed;
    logic [7:0]        rd_src;
    logic [7:0]        rd_q;
    logic              ref_q;

    bac_decode #(.BANK_W(BANK_W), .MEM_AW(MEM_AW)) u_decode (
        .addr     (reg_addr),
        .bank     (bank_eff),
        .sect     (sect),
        .mem_addr (mem_addr)
    );

    bac_bank_sel #(.BANK_W(BANK_W), .CODE_W(CODE_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (loading),
        .cfg_code (cfg_bank_code),
        .wr       (wr_ok && sect == SEC_BANKSEL),
        .wdata    (reg_wdata[BANK_W-1:0]),
        .sel      (bank_sel),
        .bank     (bank_eff)
    );

    bac_prot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_prot),
        .prot_wr  (wr_ok && sect == SEC_PROT),
        .wr_code  (reg_wdata[1:0]),
        .state    (state),
        .code     (prot_code),
        .loading  (loading)
    );

    bac_policy u_policy (
        .state (state),
        .sect  (sect),
        .rd    (reg_rd),
        .wr    (reg_wr),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .deny  (deny)
    );

    assign backed = (sect != SEC_BANKSEL) && (sect != SEC_PROT);

    always_comb begin
        unique case (sect)
            SEC_BANKSEL: rd_src = {{(8-BANK_W){1'b0}}, bank_sel};
            SEC_PROT:    rd_src = {6'b0, prot_code};
            default:     rd_src = mem_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            ref_q <= 1'b0;
        end else begin
            rd_q  <= rd_ok ? rd_src : 8'h00;
            ref_q <= deny;
        end
    end

    assign rd_data   = rd_q;
    assign refused   = ref_q;
    assign mem_we    = wr_ok & backed;
    assign mem_wdata = reg_wdata;

endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
    parameter int BANK_W = 5,
    parameter int MEM_AW = BANK_W + 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_addr,
    input logic              reg_wr,
    input logic              mem_we,
    input logic              refused,
    input logic [7:0]        rd_data,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [1:0]        prot_code
);

    AST_SHIP2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prot_code == 2'b11 |=> prot_code == 2'b11); // R7

    AST_SHIP1_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_code == 2'b10 && reg_wr && reg_addr == 8'h43) |=> prot_code[0]); // R6

    AST_CONF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_code != 2'b00 && reg_addr >= 8'h44 && reg_addr < 8'h60) |-> !mem_we); // R8

    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> rd_data == 8'h00); // R11

    AST_WE_NOT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !refused); // R11

    AST_WINDOW_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 8'h40) |-> (mem_addr[5:0] == reg_addr[5:0] && mem_addr[MEM_AW-1])); // R2

    AST_STATIC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= 8'h40) |-> mem_addr == MEM_AW'(reg_addr)); // R4

endmodule

bind bank_access_ctrl bac_checker #(.BANK_W(BANK_W), .MEM_AW(BANK_W + 7)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .mem_we    (mem_we),
    .refused   (refused),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .prot_code (prot_code)
);

// File: tb/bank_access_ctrl_tb.sv
`timescale 1ns/1ps
module bank_access_ctrl_tb;

    localparam int BW  = 3;
    localparam int MAW = BW + 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     cfg_prot = 2'b00;
    logic [2:0]     cfg_bank_code = 3'd0;
    logic [7:0]     reg_addr = 8'h00;
    logic [7:0]     reg_wdata = 8'h00;
    logic           reg_rd = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     rd_data;
    logic           refused;
    logic [MAW-1:0] mem_addr;
    logic           mem_we;
    logic [7:0]     mem_wdata;
    logic [7:0]     mem_rdata;

    logic [7:0] mem     [0:(1<<MAW)-1];
    logic [7:0] ref_mem [0:(1<<MAW)-1];

    int n_tests = 0;
    int n_fail  = 0;

    int    m_code, m_bcode, m_sel;
    int    p_rd, p_ref;
    string p_tag;

    always #4 clk = ~clk;

    bank_access_ctrl #(.BANK_W(BW), .CODE_W(3)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_prot      (cfg_prot),
        .cfg_bank_code (cfg_bank_code),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .rd_data       (rd_data),
        .refused       (refused),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    initial begin
        for (int i = 0; i < (1<<MAW); i++) begin
            mem[i]     = 8'((i * 7 + 3) & 255);
            ref_mem[i] = 8'((i * 7 + 3) & 255);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int mdl_addr(input int a);
        int lim, cnt;
        lim = (m_bcode > BW) ? BW : m_bcode;
        cnt = 1 << lim;
        if (a < 64) return (1 << (MAW-1)) + (m_sel % cnt) * 64 + a;
        return a;
    endfunction

    function automatic bit mdl_perm(input int a, input bit is_w);
        int lvl;
        lvl = (m_code == 0) ? 0 : (m_code == 1) ? 1 : 2;
        if (a == 67) return is_w ? (m_code != 3) : 1'b1;
        if (a >= 68 && a < 96) return is_w ? (lvl == 0) : (lvl < 2);
        if (a >= 96 && a < 128) return is_w ? (lvl < 2) : 1'b1;
        return 1'b1;
    endfunction

    task automatic op(input bit rd, input bit wr, input int a, input int d, input string tag);
        bit is_w, is_r, ok, backed, e_we;
        int ea, rv;
        @(negedge clk);
        chk(rd_data == 8'(p_rd), p_tag, "rd_data", rd_data, p_rd);
        chk(refused == p_ref[0], p_tag, "refused", refused, p_ref);
        is_w   = wr;
        is_r   = rd && !wr;
        ok     = mdl_perm(a, is_w);
        backed = !(a == 64 || a == 67);
        ea     = mdl_addr(a);
        e_we   = is_w && ok && backed;
        reg_rd    = rd;
        reg_wr    = wr;
        reg_addr  = 8'(a);
        reg_wdata = 8'(d);
        #1;
        chk(mem_we == e_we, tag, "mem_we", mem_we, e_we);
        if (e_we || (is_r && ok && backed))
            chk(mem_addr == MAW'(ea), tag, "mem_addr", mem_addr, ea);
        if (e_we)
            chk(mem_wdata == 8'(d), tag, "mem_wdata", mem_wdata, d);
        if (a == 64)      rv = m_sel;
        else if (a == 67) rv = m_code;
        else              rv = ref_mem[ea];
        p_ref = ((is_w || is_r) && !ok) ? 1 : 0;
        p_rd  = (is_r && ok) ? rv : 0;
        p_tag = tag;
        if (e_we) ref_mem[ea] = 8'(d);
        if (is_w && ok && a == 64) m_sel = d & ((1 << BW) - 1);
        if (is_w && ok && a == 67) begin
            if (m_code <= 1)      m_code = d & 3;
            else if (m_code == 2) m_code = ((d & 3) == 3) ? 3 : 1;
        end
    endtask

    task automatic wr_op(input int a, input int d, input string tag);
        op(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd_op(input int a, input string tag);
        op(1'b1, 1'b0, a, 0, tag);
    endtask

    task automatic do_reset(input int cp, input int cb);
        @(negedge clk);
        rst_n = 1'b0;
        reg_rd = 1'b0; reg_wr = 1'b0;
        cfg_prot = 2'(cp);
        cfg_bank_code = 3'(cb);
        repeat (2) @(negedge clk);
        chk(rd_data == 8'h00 && refused == 1'b0 && mem_we == 1'b0, "R1", "reset state",
            {rd_data, 7'b0, refused, 7'b0, mem_we}, 0);
        rst_n = 1'b1;
        reg_rd = 1'b1;
        reg_addr = 8'h70;
        #1;
        chk(mem_we == 1'b0, "R1", "mem_we in load cycle", mem_we, 0);
        p_rd = 0; p_ref = 1; p_tag = "R1";
        m_code = cp; m_bcode = cb; m_sel = 0;
    endtask

    initial begin
        #(200000 * 8);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        p_rd = 0; p_ref = 0; p_tag = "R1";
        m_code = 0; m_bcode = 0; m_sel = 0;

        // Free level, four banks
        do_reset(0, 2);
        rd_op(8'h43, "R1");
        wr_op(8'h40, 3, "R2");
        rd_op(8'h40, "R2");
        wr_op(8'h05, 8'hA5, "R2");
        rd_op(8'h05, "R2");
        wr_op(8'h40, 6, "R3");          // folds to bank 2
        rd_op(8'h40, "R3");
        wr_op(8'h05, 8'h5A, "R3");
        rd_op(8'h05, "R3");
        wr_op(8'h40, 3, "R3");
        rd_op(8'h05, "R3");
        wr_op(8'h50, 8'h11, "R4");
        wr_op(8'h40, 1, "R4");
        rd_op(8'h50, "R4");
        rd_op(8'h41, "R10");
        wr_op(8'h90, 8'h77, "R10");
        rd_op(8'h90, "R10");
        op(1'b1, 1'b1, 8'h91, 8'h3C, "R12");
        rd_op(8'h91, "R12");
        op(1'b0, 1'b0, 0, 0, "R12");

        // Level changes
        wr_op(8'h43, 1, "R5");
        rd_op(8'h43, "R5");
        wr_op(8'h48, 8'hEE, "R8");
        rd_op(8'h48, "R8");
        wr_op(8'h64, 8'h42, "R9");
        rd_op(8'h64, "R9");
        wr_op(8'h43, 0, "R5");
        wr_op(8'h48, 8'hEE, "R8");
        rd_op(8'h48, "R8");
        wr_op(8'h43, 2, "R5");
        rd_op(8'h48, "R8");
        wr_op(8'h48, 8'h99, "R11");
        op(1'b0, 1'b0, 0, 0, "R11");
        wr_op(8'h64, 8'h24, "R9");
        rd_op(8'h64, "R9");
        wr_op(8'h10, 8'hC3, "R10");
        rd_op(8'h10, "R10");
        wr_op(8'hA0, 8'h5F, "R10");
        rd_op(8'hA0, "R10");
        wr_op(8'h43, 0, "R6");
        rd_op(8'h43, "R6");
        wr_op(8'h43, 2, "R6");
        wr_op(8'h43, 3, "R6");
        rd_op(8'h43, "R6");
        wr_op(8'h43, 0, "R7");
        rd_op(8'h43, "R7");
        wr_op(8'h43, 1, "R7");
        rd_op(8'h43, "R7");
        rd_op(8'h70, "R9");

        // Preloaded shipping 2, bank code clamped to eight banks
        do_reset(3, 7);
        rd_op(8'h43, "R1");
        wr_op(8'h40, 13, "R3");
        wr_op(8'h20, 8'h81, "R3");
        rd_op(8'h20, "R3");
        rd_op(8'h50, "R8");
        wr_op(8'h43, 0, "R7");
        rd_op(8'h43, "R7");

        // Preloaded shipping 1, single bank
        do_reset(2, 0);
        rd_op(8'h43, "R1");
        wr_op(8'h40, 5, "R3");
        rd_op(8'h40, "R3");
        wr_op(8'h3F, 8'h6D, "R3");
        rd_op(8'h3F, "R3");
        wr_op(8'h43, 1, "R6");
        rd_op(8'h43, "R6");
        rd_op(8'h50, "R8");
        op(1'b0, 1'b0, 0, 0, "R12");
        op(1'b0, 1'b0, 0, 0, "R12");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule